// File: doc/BRIEF.md
# Block-Protocol Frame Header Handler

This block sits behind the CRC checker of a contactless card's receive path. It takes the bytes of a frame that has already passed its CRC, one byte per transfer, with the last byte marked. It looks at the first byte (the protocol control byte, PCB), decides what kind of block the frame is, and removes the optional card-identifier byte. It keeps the card's block-number state, which is what lets the card answer retransmission and acknowledge requests correctly. It then passes the information field of accepted frames downstream. The decision reports the block kind, an action for the command layer, and the PCB of the response the card must send.

Bits of the PCB are numbered 0 (least significant) to 7 below. An I-block has bits 7..5 = 000 and bit 1 = 1. In an I-block, bit 4 asks for chaining, bit 3 flags a card-identifier byte, bit 2 flags a node-address byte, and bit 0 carries the block number. An R-block has bits 7..5 = 101, bit 2 = 0 and bit 1 = 1. In an R-block, bit 4 distinguishes ACK (0) from NAK (1), bit 3 is the card-identifier flag and bit 0 is the block number. An S-block has bits 7..6 = 11 and bits 2..0 = 010. A PCB that matches none of these is invalid.

Input and output byte streams use valid/ready. A transfer happens on a rising edge where both valid and ready are high. The upstream must hold `in_data` and `in_last` stable while `in_valid` is high and `in_ready` is low. The block never stores a payload byte: while it passes an information field, `in_ready` follows `out_ready`, so downstream back-pressure stalls the upstream directly. Header bytes, and the bodies of frames that are dropped, are always accepted at once. The PCB, the card-identifier byte and the body of a dropped frame never appear on the output stream.

Top module: `blkhdr_top`

## Requirements
- R1: After reset, `dec_valid` and `out_valid` are 0 and `in_ready` is 1, and the next expected I-block number is 0.
- R2: `dec_kind` reports the PCB class: 0 for I-block, 1 for R-block, 2 for S-block, 3 for invalid.
- R3: An I-block with PCB bit 4 (chaining) or bit 2 (node address) set gets `dec_act` = 0 (drop), with `resp_pcb` = 0x00 and no output bytes.
- R4: If PCB bit 3 is set, the byte after the PCB is the card-identifier byte, and its low 4 bits must equal `cid_val` while `cid_en` is 1. A frame is dropped if its card identifier does not match, if it carries that byte while `cid_en` is 0, or if it lacks it while `cid_en` is 1. A response PCB has bit 3 equal to `cid_en`.
- R5: An I-block whose bit 0 equals the expected number gets `dec_act` = 1 (execute) and `resp_pcb` = {0000, cid_en, 0, 1, bit 0}, and the expected number toggles. An I-block with the other number is dropped and the number is kept.
- R6: An R-block, ACK or NAK, whose bit 0 equals the number of the last executed I-block gets `dec_act` = 2 (resend last response) with `resp_pcb` = 0x00. After reset or activation that number counts as 1.
- R7: Any other R-block gets `dec_act` = 3 (send R(ACK)) with `resp_pcb` = {1010, cid_en, 0, 1, last executed number}.
- R8: An S-block gets `dec_act` = 4 (forward) with `resp_pcb` = 0x00. An invalid PCB gets `dec_act` = 0.
- R9: For decisions 1 and 4, the bytes after the header leave on `out_data` in order, and `out_first` is high with the first of them. For every other decision those bytes are consumed and none is output.
- R10: While a body is passed, `in_ready` equals `out_ready` whenever `in_valid` is high.
- R11: `dec_valid` pulses for one cycle, in the cycle after the transfer of the last header byte, together with `dec_kind`, `dec_act`, `dec_accept` (1 unless the action is 0) and `resp_pcb`.
- R12: A one-cycle pulse on `activate` returns the expected I-block number to 0.
- R13: A frame whose PCB has bit 3 set but that ends at the PCB is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| activate | input | 1 | Pulse: card entered the active state, block number restarts |
| cid_en | input | 1 | Card identifiers are in use |
| cid_val | input | 4 | Configured card identifier |
| in_valid | input | 1 | Frame byte available |
| in_ready | output | 1 | Frame byte taken on this edge if valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of the frame |
| out_valid | output | 1 | Information-field byte available |
| out_ready | input | 1 | Downstream can take the byte |
| out_data | output | 8 | Information-field byte |
| out_last | output | 1 | Byte is the last of the frame |
| out_first | output | 1 | Byte is the first of the information field |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_kind | output | 2 | Block class (R2) |
| dec_act | output | 3 | Action: 0 drop, 1 execute, 2 resend, 3 send R(ACK), 4 forward |
| dec_accept | output | 1 | Action is not drop |
| resp_pcb | output | 8 | PCB of the response to send |

## Verification
The bench focuses on where the block-number state can go wrong. It sends a repeated I-block with a stale number, and an ACK and a NAK that each hit and miss the last executed number. A design that toggled on every I-block, or that compared R-blocks against the expected number, would resend when it should acknowledge, or the other way round. It also sends frames with mismatched or unexpected card identifiers, a card-identifier byte whose high bits are set, and a frame cut short after a PCB that promises that byte. A parser that counted header length wrongly would leak the identifier byte into the payload or shift the decision by one cycle. A back-pressured body checks that no byte is lost or duplicated while `out_ready` toggles.

// File: rtl/blkhdr_pkg.sv
package blkhdr_pkg;

  localparam int unsigned PCB_W = 8;

  typedef enum logic [1:0] {
    BT_I   = 2'd0,
    BT_R   = 2'd1,
    BT_S   = 2'd2,
    BT_BAD = 2'd3
  } blk_kind_e;

  typedef enum logic [2:0] {
    ACT_DROP   = 3'd0,
    ACT_EXEC   = 3'd1,
    ACT_RESEND = 3'd2,
    ACT_RACK   = 3'd3,
    ACT_FWD    = 3'd4
  } blk_act_e;

  // fixed-bit masks and patterns of the three block classes
  localparam logic [PCB_W-1:0] I_MASK = 8'hE2, I_PAT = 8'h02;
  localparam logic [PCB_W-1:0] R_MASK = 8'hE6, R_PAT = 8'hA2;
  localparam logic [PCB_W-1:0] S_MASK = 8'hC7, S_PAT = 8'hC2;

endpackage

// File: rtl/blkhdr_classify.sv
module blkhdr_classify
  import blkhdr_pkg::*;
(
  input  logic [PCB_W-1:0] pcb,
  output blk_kind_e        kind,
  output logic             f_chain,
  output logic             f_nad,
  output logic             f_bn
);

  always_comb begin
    if ((pcb & I_MASK) == I_PAT)      kind = BT_I;
    else if ((pcb & R_MASK) == R_PAT) kind = BT_R;
    else if ((pcb & S_MASK) == S_PAT) kind = BT_S;
    else                              kind = BT_BAD;
  end

  assign f_chain = pcb[4];
  assign f_nad   = pcb[2];
  assign f_bn    = pcb[0];

endmodule

// File: rtl/blkhdr_seq.sv
module blkhdr_seq
  import blkhdr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             activate,
  input  logic             cid_en,
  input  logic             hdr_done,
  input  logic [PCB_W-1:0] hdr_pcb,
  input  logic             hdr_cid_ok,
  output blk_act_e         act_now,
  output logic             dec_valid,
  output blk_kind_e        dec_kind,
  output blk_act_e         dec_act,
  output logic [PCB_W-1:0] dec_resp
);

  blk_kind_e        kind;
  logic             f_chain, f_nad, f_bn;
  logic             exp_q;
  logic [PCB_W-1:0] resp_c;

  blkhdr_classify u_cls (
    .pcb     (hdr_pcb),
    .kind    (kind),
    .f_chain (f_chain),
    .f_nad   (f_nad),
    .f_bn    (f_bn)
  );

  // decision from the header and the expected block number
  always_comb begin
    act_now = ACT_DROP;
    resp_c  = '0;
    unique case (kind)
      BT_I: begin
        if (hdr_cid_ok && !f_chain && !f_nad && (f_bn == exp_q)) begin
          act_now = ACT_EXEC;
          resp_c  = {4'h0, cid_en, 2'b01, f_bn};
        end
      end
      BT_R: begin
        if (hdr_cid_ok) begin
          if (f_bn == ~exp_q) begin
            act_now = ACT_RESEND;
          end else begin
            act_now = ACT_RACK;
            resp_c  = {4'hA, cid_en, 2'b01, ~exp_q};
          end
        end
      end
      BT_S: begin
        if (hdr_cid_ok) act_now = ACT_FWD;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q     <= 1'b0;
      dec_valid <= 1'b0;
      dec_kind  <= BT_I;
      dec_act   <= ACT_DROP;
      dec_resp  <= '0;
    end else begin
      dec_valid <= hdr_done;
      if (hdr_done) begin
        dec_kind <= kind;
        dec_act  <= act_now;
        dec_resp <= resp_c;
      end
      if (activate)
        exp_q <= 1'b0;
      else if (hdr_done && act_now == ACT_EXEC)
        exp_q <= ~exp_q;
    end
  end

  // R5: an executed I-block moves the expected number on
  a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_act == ACT_EXEC && !$past(activate)) |-> (exp_q != $past(exp_q)));

  // R5: execute responses are I-block PCBs
  a_r5_resp_iform: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_act == ACT_EXEC) |-> (dec_resp[7:5] == 3'b000 && dec_resp[1]));

  // R3: dropped frames carry no response PCB
  a_r3_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_act == ACT_DROP) |-> (dec_resp == '0));

  // R8: only S-blocks are forwarded
  a_r8_fwd_is_s: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_act == ACT_FWD) |-> (dec_kind == BT_S));

endmodule

// File: rtl/blkhdr_parse.sv
module blkhdr_parse
  import blkhdr_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned CID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cid_en,
  input  logic [CID_W-1:0] cid_val,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_last,
  output logic             out_first,
  input  blk_act_e         act_now,
  output logic             hdr_done,
  output logic [PCB_W-1:0] hdr_pcb,
  output logic             hdr_cid_ok
);

  typedef enum logic [1:0] {PS_PCB, PS_CID, PS_BODY} ps_e;

  ps_e              st;
  logic [PCB_W-1:0] pcb_q;
  logic             keep_q, first_q;
  logic             fire, cflag, keep_c;

  assign fire    = in_valid && in_ready;
  assign hdr_pcb = (st == PS_PCB) ? in_data[PCB_W-1:0] : pcb_q;
  assign cflag   = hdr_pcb[3];

  assign hdr_done = fire && ((st == PS_PCB && (!cflag || in_last)) || st == PS_CID);

  always_comb begin
    if (st == PS_CID) hdr_cid_ok = cid_en && (in_data[CID_W-1:0] == cid_val);
    else              hdr_cid_ok = !cflag && !cid_en;
  end

  assign keep_c = (act_now == ACT_EXEC) || (act_now == ACT_FWD);

  assign in_ready  = (st == PS_BODY && keep_q) ? out_ready : 1'b1;
  assign out_valid = (st == PS_BODY) && keep_q && in_valid;
  assign out_data  = in_data;
  assign out_last  = in_last;
  assign out_first = out_valid && first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= PS_PCB;
      pcb_q   <= '0;
      keep_q  <= 1'b0;
      first_q <= 1'b0;
    end else if (fire) begin
      if (hdr_done) begin
        keep_q  <= keep_c;
        first_q <= 1'b1;
      end else if (st == PS_BODY) begin
        first_q <= 1'b0;
      end
      unique case (st)
        PS_PCB: begin
          pcb_q <= in_data[PCB_W-1:0];
          if (in_last)    st <= PS_PCB;
          else if (cflag) st <= PS_CID;
          else            st <= PS_BODY;
        end
        PS_CID:  st <= in_last ? PS_PCB : PS_BODY;
        default: if (in_last) st <= PS_PCB;
      endcase
    end
  end

  // R10: a stalled output byte is never taken from the input
  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9: the first-byte mark appears once per body
  a_r9_first_once: assert property (@(posedge clk) disable iff (!rst_n)
    (out_first && out_ready) |=> !out_first);

endmodule

// File: rtl/blkhdr_top.sv
module blkhdr_top
  import blkhdr_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned CID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             activate,
  input  logic             cid_en,
  input  logic [CID_W-1:0] cid_val,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_data,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             out_last,
  output logic             out_first,
  output logic             dec_valid,
  output logic [1:0]       dec_kind,
  output logic [2:0]       dec_act,
  output logic             dec_accept,
  output logic [7:0]       resp_pcb
);

  blk_act_e         act_now;
  logic             hdr_done, hdr_cid_ok;
  logic [PCB_W-1:0] hdr_pcb;
  blk_kind_e        kind_q;
  blk_act_e         act_q;

  blkhdr_parse #(.DW(DW), .CID_W(CID_W)) u_parse (
    .clk        (clk),
    .rst_n      (rst_n),
    .cid_en     (cid_en),
    .cid_val    (cid_val),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .in_last    (in_last),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last),
    .out_first  (out_first),
    .act_now    (act_now),
    .hdr_done   (hdr_done),
    .hdr_pcb    (hdr_pcb),
    .hdr_cid_ok (hdr_cid_ok)
  );

  blkhdr_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .activate   (activate),
    .cid_en     (cid_en),
    .hdr_done   (hdr_done),
    .hdr_pcb    (hdr_pcb),
    .hdr_cid_ok (hdr_cid_ok),
    .act_now    (act_now),
    .dec_valid  (dec_valid),
    .dec_kind   (kind_q),
    .dec_act    (act_q),
    .dec_resp   (resp_pcb)
  );

  assign dec_kind   = kind_q;
  assign dec_act    = act_q;
  assign dec_accept = (act_q != ACT_DROP);

endmodule

// File: tb/blkhdr_top_tb_top.sv
module blkhdr_top_tb_top;

  typedef struct packed {
    logic        en;
    logic [3:0]  cv;
    logic [2:0]  len;
    logic [31:0] b;
    logic [1:0]  k;
    logic [2:0]  a;
    logic [7:0]  r;
    logic [2:0]  n;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 19;
  // frame bytes packed low byte first; expected kind, action, response, body count
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'h0, 3'd1, 32'h000000A3, 2'd1, 3'd2, 8'h00, 3'd0, 4'd6},  // R6 ACK hits initial 1
    '{1'b0, 4'h0, 3'd1, 32'h000000B2, 2'd1, 3'd3, 8'hA3, 3'd0, 4'd7},  // R7 NAK misses
    '{1'b0, 4'h0, 3'd3, 32'h00221102, 2'd0, 3'd1, 8'h02, 3'd2, 4'd5},  // R5 I0 executes
    '{1'b0, 4'h0, 3'd2, 32'h00003302, 2'd0, 3'd0, 8'h00, 3'd0, 4'd5},  // R5 stale I0
    '{1'b0, 4'h0, 3'd2, 32'h00004413, 2'd0, 3'd0, 8'h00, 3'd0, 4'd3},  // R3 chaining
    '{1'b0, 4'h0, 3'd2, 32'h00005507, 2'd0, 3'd0, 8'h00, 3'd0, 4'd3},  // R3 node address
    '{1'b0, 4'h0, 3'd1, 32'h000000B2, 2'd1, 3'd2, 8'h00, 3'd0, 4'd6},  // R6 NAK hits 0
    '{1'b0, 4'h0, 3'd1, 32'h000000A3, 2'd1, 3'd3, 8'hA2, 3'd0, 4'd7},  // R7 ACK misses
    '{1'b0, 4'h0, 3'd4, 32'hCCBBAA03, 2'd0, 3'd1, 8'h03, 3'd3, 4'd9},  // R9 I1 three bytes
    '{1'b0, 4'h0, 3'd2, 32'h000001C2, 2'd2, 3'd4, 8'h00, 3'd1, 4'd8},  // R8 S-block
    '{1'b0, 4'h0, 3'd2, 32'h00006642, 2'd3, 3'd0, 8'h00, 3'd0, 4'd8},  // R8 invalid
    '{1'b0, 4'h0, 3'd3, 32'h0077000A, 2'd0, 3'd0, 8'h00, 3'd0, 4'd4},  // R4 id byte, ids off
    '{1'b1, 4'h5, 3'd3, 32'h0088050A, 2'd0, 3'd1, 8'h0A, 3'd1, 4'd4},  // R4 id match
    '{1'b1, 4'h5, 3'd3, 32'h0099030B, 2'd0, 3'd0, 8'h00, 3'd0, 4'd4},  // R4 id mismatch
    '{1'b1, 4'h5, 3'd2, 32'h0000AA03, 2'd0, 3'd0, 8'h00, 3'd0, 4'd4},  // R4 id byte missing
    '{1'b1, 4'h5, 3'd3, 32'h0012450B, 2'd0, 3'd1, 8'h0B, 3'd1, 4'd4},  // R4 high bits ignored
    '{1'b1, 4'h5, 3'd2, 32'h000005BA, 2'd1, 3'd3, 8'hAB, 3'd0, 4'd7},  // R7 with id
    '{1'b1, 4'h5, 3'd1, 32'h0000000A, 2'd0, 3'd0, 8'h00, 3'd0, 4'd13}, // R13 cut short
    '{1'b0, 4'h0, 3'd1, 32'h00000002, 2'd0, 3'd1, 8'h02, 3'd0, 4'd5}   // R5 empty body
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       activate = 1'b0;
  logic       cid_en = 1'b0;
  logic [3:0] cid_val = 4'h0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       in_last = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       out_last;
  logic       out_first;
  logic       dec_valid;
  logic [1:0] dec_kind;
  logic [2:0] dec_act;
  logic       dec_accept;
  logic [7:0] resp_pcb;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;
  bit finished = 0;

  // per-frame observations
  int         dec_cnt, dec_cyc, hdr_cyc, out_cnt, data_bad, first_bad, bp_bad;
  logic [1:0] seen_k;
  logic [2:0] seen_a;
  logic [7:0] seen_r;
  logic       seen_acc;

  always #10 clk = ~clk;

  blkhdr_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .activate   (activate),
    .cid_en     (cid_en),
    .cid_val    (cid_val),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .in_last    (in_last),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_last   (out_last),
    .out_first  (out_first),
    .dec_valid  (dec_valid),
    .dec_kind   (dec_kind),
    .dec_act    (dec_act),
    .dec_accept (dec_accept),
    .resp_pcb   (resp_pcb)
  );

  function automatic string tag_s(input logic [3:0] t);
    case (t)
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R13";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [2:0] len, input logic [31:0] b, input bit bp);
    int idx = 0;
    int hlen = b[3] ? 2 : 1;
    int hend = ((hlen < int'(len)) ? hlen : int'(len)) - 1;
    dec_cnt = 0; dec_cyc = -1; hdr_cyc = -9; out_cnt = 0;
    data_bad = 0; first_bad = 0; bp_bad = 0;
    for (int c = 0; c < int'(len) * 3 + 4; c++) begin
      @(negedge clk);
      out_ready = bp ? c[0] : 1'b1;
      if (idx < int'(len)) begin
        in_valid = 1'b1;
        in_data  = b[idx*8 +: 8];
        in_last  = (idx == int'(len) - 1);
      end else begin
        in_valid = 1'b0;
        in_data  = 8'h00;
        in_last  = 1'b0;
      end
      #1;
      if (dec_valid) begin
        dec_cnt++; dec_cyc = c;
        seen_k = dec_kind; seen_a = dec_act; seen_r = resp_pcb; seen_acc = dec_accept;
      end
      if (out_valid && out_ready) begin
        if (out_data !== b[(hlen + out_cnt)*8 +: 8]) data_bad++;
        if (out_first !== (out_cnt == 0)) first_bad++;
        out_cnt++;
      end
      if (out_valid && (in_ready !== out_ready)) bp_bad++;
      if (in_valid && in_ready) begin
        if (idx == hend) hdr_cyc = c;
        idx++;
      end
    end
    in_valid = 1'b0;
    in_last = 1'b0;
    out_ready = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1: idle state under and after reset
    chk("R1", "dec_valid in reset", int'(dec_valid), 0);
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R1", "in_ready in reset", int'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", "dec_valid after reset", int'(dec_valid), 0);
    chk("R1", "in_ready after reset", int'(in_ready), 1);

    for (int v = 0; v < NV; v++) begin
      cid_en  = VEC[v].en;
      cid_val = VEC[v].cv;
      run_frame(VEC[v].len, VEC[v].b, 1'b0);
      chk("R11", $sformatf("vec %0d decision count", v), dec_cnt, 1);
      chk("R11", $sformatf("vec %0d decision cycle", v), dec_cyc, hdr_cyc + 1);
      chk("R2", $sformatf("vec %0d kind", v), int'(seen_k), int'(VEC[v].k));
      chk(tag_s(VEC[v].tag), $sformatf("vec %0d action", v), int'(seen_a), int'(VEC[v].a));
      chk(tag_s(VEC[v].tag), $sformatf("vec %0d response", v), int'(seen_r), int'(VEC[v].r));
      chk("R11", $sformatf("vec %0d accept", v), int'(seen_acc), int'(VEC[v].a != 3'd0));
      chk("R9", $sformatf("vec %0d body bytes", v), out_cnt, int'(VEC[v].n));
      chk("R9", $sformatf("vec %0d body data", v), data_bad, 0);
      chk("R9", $sformatf("vec %0d first mark", v), first_bad, 0);
    end

    // R12: expected number is 1 here; activation brings it back to 0
    cid_en = 1'b0;
    cid_val = 4'h0;
    @(negedge clk);
    activate = 1'b1;
    @(negedge clk);
    activate = 1'b0;
    run_frame(3'd2, 32'h00005A02, 1'b0);
    chk("R12", "I0 after activation action", int'(seen_a), 1);
    chk("R12", "I0 after activation response", int'(seen_r), 8'h02);

    // R10: body under toggling back-pressure, expected number now 1
    run_frame(3'd4, 32'h03020103, 1'b1);
    chk("R10", "stalled body action", int'(seen_a), 1);
    chk("R10", "stalled body bytes", out_cnt, 3);
    chk("R10", "stalled body data", data_bad, 0);
    chk("R10", "ready follows downstream", bp_bad, 0);
    chk("R10", "first mark under stall", first_bad, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule